// File: doc/BRIEF.md
# Inter-Processor Interrupt Flag Unit

This block lets processors signal one another. It keeps one pending flag and one mask bit for each of `NUM_CPU` processors, and it drives one interrupt output per processor. That output is high while the processor's flag is set and its mask bit is clear. Software works on the flags and masks through set/clear register pairs on a 32-bit register bus. A write to the SET address of a pair raises the bits written as 1. A write to the CLR address lowers them. A read of either address returns the current vector.

The block also supplies the interrupt reason register, which it shares with the hardware interrupt distributor. Each bus access carries a requester ID. A reason read reports the reason for that requester only. A pending hardware interrupt for the requester is reported first, and the distributor is told through an acknowledge pulse. Otherwise, if the requester has an unmasked inter-processor interrupt, the read reports it and sets that requester's mask bit, which removes the interrupt. To finish handling, software clears the flag and then clears the mask. If the flag is still set when the mask is cleared, the interrupt comes back at once.

Top module: `ipi_flag_unit`

## Requirements
- R1: After reset, every flag is 0, every mask bit is 1, `irqOut` is 0 and `busRdata` is 0.
- R2: A write to 0x2008 (flag SET) sets each flag bit i for which `busWdata[i]` is 1 and leaves the others unchanged. `irqOut[i]` equals flag[i] AND NOT mask[i], and it reflects a write from the clock edge that captures the write.
- R3: A write to 0x200C (flag CLR) clears each flag bit whose `busWdata` bit is 1 and leaves the others unchanged.
- R4: A write to 0x2024 (mask SET) sets mask bits, and a write to 0x2028 (mask CLR) clears mask bits, in each case for the bits written as 1.
- R5: A read of 0x2008 or 0x200C returns the flag vector in bits NUM_CPU-1:0. A read of 0x2024 or 0x2028 returns the mask vector. Upper bits read 0. Read data is registered and is valid in the cycle after the read.
- R6: A read of 0x2004 (reason) by requester r, with no hardware interrupt pending for r and `irqOut[r]` high, returns 0x00020000 (type code 2 in bits 31:16). The same read sets mask[r], so `irqOut[r]` falls one cycle later. The bits of the other processors do not change.
- R7: A reason read by requester r while `hwPend[r]` is 1 returns {16'h0001, `hwNum`}. `hwAck` is high for exactly the cycle in which that data is presented. The inter-processor mask is left unchanged.
- R8: A reason read with nothing pending for the requester returns 0 and changes no state.
- R9: A mask CLR write to a bit whose flag is still set raises that `irqOut` bit again in the next cycle.
- R10: A write to the reason address or to an unmapped address changes no state. A read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Bus access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 16 | Byte address |
| busWdata | input | 32 | Write data |
| busReqId | input | 3 | Requesting processor |
| busRdata | output | 32 | Registered read data |
| hwPend | input | 8 | Hardware interrupt pending, per processor, from the distributor |
| hwNum | input | 16 | Number of the hardware interrupt being reported |
| hwAck | output | 1 | Pulse: a hardware reason was delivered |
| irqOut | output | 8 | Interrupt line per processor |

## Verification
A wrong flag or mask bit shows on `irqOut` in the cycle after the write that caused it. It also shows on the read data one cycle after a read of either register of the pair. If the auto-mask is taken from the wrong requester, a different `irqOut` bit falls after the reason read, and the mask read-back shows the wrong bit set. A priority error between hardware and inter-processor reasons shows at once in the type code of the reason data, in `hwAck`, and in whether the requester's line drops.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int CODE_W = DATA_W / 2;

  localparam logic [ADDR_W-1:0] OFS_REASON   = 16'h2004;
  localparam logic [ADDR_W-1:0] OFS_FLAG_SET = 16'h2008;
  localparam logic [ADDR_W-1:0] OFS_FLAG_CLR = 16'h200C;
  localparam logic [ADDR_W-1:0] OFS_MASK_SET = 16'h2024;
  localparam logic [ADDR_W-1:0] OFS_MASK_CLR = 16'h2028;

  localparam logic [CODE_W-1:0] TYPE_NONE = 16'd0;
  localparam logic [CODE_W-1:0] TYPE_HW   = 16'd1;
  localparam logic [CODE_W-1:0] TYPE_IPI  = 16'd2;

  typedef enum logic [1:0] {
    SEL_ZERO   = 2'd0,
    SEL_FLAG   = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_REASON = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   flagSet;
    logic   flagClr;
    logic   maskSet;
    logic   maskClr;
    logic   reasonRd;
    logic   rdEn;
    rdSel_e rdSel;
  } ipiStrobe_t;

endpackage

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
(
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output ipiStrobe_t        strobe
);

  logic hitReason;
  logic hitFlagSet;
  logic hitFlagClr;
  logic hitMaskSet;
  logic hitMaskClr;
  logic doWrite;
  logic doRead;

  assign hitReason  = (busAddr == OFS_REASON);
  assign hitFlagSet = (busAddr == OFS_FLAG_SET);
  assign hitFlagClr = (busAddr == OFS_FLAG_CLR);
  assign hitMaskSet = (busAddr == OFS_MASK_SET);
  assign hitMaskClr = (busAddr == OFS_MASK_CLR);

  assign doWrite = busValid && busWrite;
  assign doRead  = busValid && !busWrite;

  always_comb begin
    strobe          = '0;
    strobe.flagSet  = doWrite && hitFlagSet;
    strobe.flagClr  = doWrite && hitFlagClr;
    strobe.maskSet  = doWrite && hitMaskSet;
    strobe.maskClr  = doWrite && hitMaskClr;
    strobe.reasonRd = doRead && hitReason;
    strobe.rdEn     = doRead;
    strobe.rdSel    = SEL_ZERO;
    if (hitFlagSet || hitFlagClr) begin
      strobe.rdSel = SEL_FLAG;
    end else if (hitMaskSet || hitMaskClr) begin
      strobe.rdSel = SEL_MASK;
    end else if (hitReason) begin
      strobe.rdSel = SEL_REASON;
    end
  end

endmodule

// File: rtl/ipi_datapath.sv
module ipi_datapath
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  localparam int ID_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ipiStrobe_t         strobe,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [ID_W-1:0]    reqId,
  input  logic [NUM_CPU-1:0] hwPend,
  input  logic [CODE_W-1:0]  hwNum,
  output logic [NUM_CPU-1:0] flagQ,
  output logic [NUM_CPU-1:0] maskQ,
  output logic [NUM_CPU-1:0] irqOut,
  output logic [DATA_W-1:0]  rdata,
  output logic               hwAck
);

  logic [NUM_CPU-1:0] wBits;
  logic [NUM_CPU-1:0] reqSel;
  logic [NUM_CPU-1:0] ipiLive;
  logic               reqHw;
  logic               reqIpi;
  logic               takeHw;
  logic               takeIpi;
  logic [DATA_W-1:0]  reasonWord;
  logic [DATA_W-1:0]  rdNext;

  assign wBits   = wdata[NUM_CPU-1:0];
  assign ipiLive = flagQ & ~maskQ;
  assign irqOut  = ipiLive;

  generate
    if (NUM_CPU < DATA_W) begin : g_spare
      logic unusedHighBits;
      assign unusedHighBits = ^wdata[DATA_W-1:NUM_CPU];
    end
  endgenerate

  // one-hot decode of the requester; out-of-range IDs select nothing
  generate
    for (genvar i = 0; i < NUM_CPU; i++) begin : g_sel
      assign reqSel[i] = (reqId == ID_W'(i));
    end
  endgenerate

  assign reqHw   = |(reqSel & hwPend);
  assign reqIpi  = |(reqSel & ipiLive);
  assign takeHw  = strobe.reasonRd && reqHw;
  assign takeIpi = strobe.reasonRd && !reqHw && reqIpi;

  // per-processor flag and mask storage
  generate
    for (genvar i = 0; i < NUM_CPU; i++) begin : g_bit
      logic flagUp;
      logic flagDown;
      logic maskUp;
      logic maskDown;

      assign flagUp   = strobe.flagSet && wBits[i];
      assign flagDown = strobe.flagClr && wBits[i];
      assign maskUp   = (strobe.maskSet && wBits[i]) || (takeIpi && reqSel[i]);
      assign maskDown = strobe.maskClr && wBits[i];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          flagQ[i] <= 1'b0;
          maskQ[i] <= 1'b1;
        end else begin
          if (flagUp) begin
            flagQ[i] <= 1'b1;
          end else if (flagDown) begin
            flagQ[i] <= 1'b0;
          end
          if (maskUp) begin
            maskQ[i] <= 1'b1;
          end else if (maskDown) begin
            maskQ[i] <= 1'b0;
          end
        end
      end
    end
  endgenerate

  always_comb begin
    if (reqHw) begin
      reasonWord = {TYPE_HW, hwNum};
    end else if (reqIpi) begin
      reasonWord = {TYPE_IPI, {CODE_W{1'b0}}};
    end else begin
      reasonWord = {TYPE_NONE, {CODE_W{1'b0}}};
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_FLAG:   rdNext = DATA_W'(flagQ);
      SEL_MASK:   rdNext = DATA_W'(maskQ);
      SEL_REASON: rdNext = reasonWord;
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata <= '0;
      hwAck <= 1'b0;
    end else begin
      hwAck <= takeHw;
      if (strobe.rdEn) begin
        rdata <= rdNext;
      end
    end
  end

endmodule

// File: rtl/ipi_flag_unit.sv
module ipi_flag_unit
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  localparam int ID_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [ID_W-1:0]    busReqId,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_CPU-1:0] hwPend,
  input  logic [CODE_W-1:0]  hwNum,
  output logic               hwAck,
  output logic [NUM_CPU-1:0] irqOut
);

  ipiStrobe_t         strobe;
  logic [NUM_CPU-1:0] flagState;
  logic [NUM_CPU-1:0] maskState;

  ipi_ctrl u_ctrl (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobe   (strobe)
  );

  ipi_datapath #(.NUM_CPU(NUM_CPU)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wdata  (busWdata),
    .reqId  (busReqId),
    .hwPend (hwPend),
    .hwNum  (hwNum),
    .flagQ  (flagState),
    .maskQ  (maskState),
    .irqOut (irqOut),
    .rdata  (busRdata),
    .hwAck  (hwAck)
  );

endmodule

// File: rtl/ipi_flag_unit_chk.sv
module ipi_flag_unit_chk
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  localparam int ID_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic               clk,
  input logic               rstN,
  input logic               busValid,
  input logic               busWrite,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWdata,
  input logic [ID_W-1:0]    busReqId,
  input logic [DATA_W-1:0]  busRdata,
  input logic [NUM_CPU-1:0] hwPend,
  input logic [CODE_W-1:0]  hwNum,
  input logic               hwAck,
  input logic [NUM_CPU-1:0] irqOut,
  input logic [NUM_CPU-1:0] flagState,
  input logic [NUM_CPU-1:0] maskState
);

  logic               wrOp;
  logic               rdReason;
  logic [NUM_CPU-1:0] wBits;

  assign wrOp     = busValid && busWrite;
  assign rdReason = busValid && !busWrite && (busAddr == OFS_REASON);
  assign wBits    = busWdata[NUM_CPU-1:0];

  // R2: bits written to flag SET are set afterwards
  assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrOp && busAddr == OFS_FLAG_SET) |=> ((flagState & $past(wBits)) == $past(wBits)));

  // R3: bits written to flag CLR are clear afterwards
  assert_flag_clr_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrOp && busAddr == OFS_FLAG_CLR) |=> ((flagState & $past(wBits)) == '0));

  // R6: IPI acknowledge drops the requester's line
  assert_ack_masks_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdReason && (hwPend[busReqId] == 1'b0) && irqOut[busReqId])
      |=> (irqOut[$past(busReqId)] == 1'b0) && (busRdata == 32'h0002_0000));

  // R7: hardware reason wins and acknowledges the distributor
  assert_hw_priority_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdReason && hwPend[busReqId])
      |=> hwAck && (busRdata == {TYPE_HW, $past(hwNum)}) && (maskState == $past(maskState)));

  // R7: no acknowledge without a reason read
  assert_ack_only_on_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    !rdReason |=> !hwAck);

  // R9: unmasking a still-set flag reasserts the line
  assert_unmask_reassert_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrOp && busAddr == OFS_MASK_CLR)
      |=> ((irqOut & $past(wBits & flagState)) == $past(wBits & flagState)));

endmodule

bind ipi_flag_unit ipi_flag_unit_chk #(.NUM_CPU(NUM_CPU)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busValid  (busValid),
  .busWrite  (busWrite),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .busReqId  (busReqId),
  .busRdata  (busRdata),
  .hwPend    (hwPend),
  .hwNum     (hwNum),
  .hwAck     (hwAck),
  .irqOut    (irqOut),
  .flagState (flagState),
  .maskState (maskState)
);

// File: tb/ipi_flag_unit_tb.sv
module ipi_flag_unit_tb;
  import ipi_pkg::*;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [15:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [2:0]  busReqId = '0;
  logic [31:0] busRdata;
  logic [N-1:0] hwPend = '0;
  logic [15:0] hwNum = '0;
  logic        hwAck;
  logic [N-1:0] irqOut;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  ipi_flag_unit #(.NUM_CPU(N)) u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busReqId(busReqId),
    .busRdata(busRdata), .hwPend(hwPend), .hwNum(hwNum),
    .hwAck(hwAck), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // drive on falling edge; results are sampled at the next falling edge
  task automatic busWr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [15:0] a, input logic [2:0] id, output logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a; busReqId = id;
    @(negedge clk);
    busValid = 1'b0;
    d = busRdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irqOut", 32'(irqOut), 32'h0);
    check("R1 rdata", busRdata, 32'h0);
    busRd(16'h2008, 3'd0, d);
    check("R1 flags", d, 32'h0);
    busRd(16'h2028, 3'd0, d);
    check("R1 masks", d, 32'h0000_00FF);
  endtask

  task automatic t_set_and_readback();
    logic [31:0] d;
    busWr(16'h2028, 32'hFFFF_FFFF);
    check("R4 unmask all", 32'(irqOut), 32'h0);
    busWr(16'h2008, 32'h0000_0005);
    check("R2 irqOut after set", 32'(irqOut), 32'h05);
    busWr(16'h2008, 32'h0);
    check("R2 zero write keeps", 32'(irqOut), 32'h05);
    busRd(16'h200C, 3'd1, d);
    check("R5 flag via CLR addr", d, 32'h05);
    busRd(16'h2024, 3'd1, d);
    check("R5 mask via SET addr", d, 32'h0);
  endtask

  task automatic t_clear();
    busWr(16'h200C, 32'h0000_0001);
    check("R3 flag clr", 32'(irqOut), 32'h04);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    busWr(16'h2024, 32'h0000_0004);
    check("R4 mask set", 32'(irqOut), 32'h0);
    busRd(16'h2028, 3'd0, d);
    check("R5 mask readback", d, 32'h04);
    busWr(16'h2028, 32'h0000_0004);
    check("R9 unmask reasserts", 32'(irqOut), 32'h04);
  endtask

  task automatic t_ipi_ack();
    logic [31:0] d;
    busRd(16'h2004, 3'd2, d);
    check("R6 reason word", d, 32'h0002_0000);
    check("R6 line dropped", 32'(irqOut), 32'h0);
    check("R6 no hwAck", 32'(hwAck), 32'h0);
    busRd(16'h2024, 3'd2, d);
    check("R6 own mask only", d, 32'h04);
    busWr(16'h200C, 32'h04);
    busWr(16'h2028, 32'h04);
    check("R9 cleared flag stays low", 32'(irqOut), 32'h0);
    busWr(16'h2008, 32'h08);
    check("R2 second target", 32'(irqOut), 32'h08);
    busRd(16'h2004, 3'd3, d);
    check("R6 second ack", d, 32'h0002_0000);
    check("R6 second drop", 32'(irqOut), 32'h0);
    busWr(16'h2028, 32'h08);
    check("R9 reassert flag left set", 32'(irqOut), 32'h08);
  endtask

  task automatic t_hw();
    logic [31:0] d;
    hwPend = 8'h08; hwNum = 16'h1234;
    busRd(16'h2004, 3'd3, d);
    check("R7 hw reason", d, 32'h0001_1234);
    check("R7 hwAck", 32'(hwAck), 32'h1);
    check("R7 ipi untouched", 32'(irqOut), 32'h08);
    @(negedge clk);
    check("R7 hwAck one cycle", 32'(hwAck), 32'h0);
    hwPend = '0;
    busRd(16'h2024, 3'd3, d);
    check("R7 mask unchanged", d, 32'h0);
  endtask

  task automatic t_none();
    logic [31:0] d;
    busRd(16'h2004, 3'd5, d);
    check("R8 empty reason", d, 32'h0);
    check("R8 lines unchanged", 32'(irqOut), 32'h08);
    busRd(16'h2028, 3'd5, d);
    check("R8 masks unchanged", d, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    busWr(16'h2010, 32'hFFFF_FFFF);
    busWr(16'h2004, 32'hFFFF_FFFF);
    check("R10 lines unchanged", 32'(irqOut), 32'h08);
    busRd(16'h2010, 3'd0, d);
    check("R10 unmapped reads 0", d, 32'h0);
    busRd(16'h2008, 3'd0, d);
    check("R10 flags unchanged", d, 32'h08);
    busRd(16'h2024, 3'd0, d);
    check("R10 masks unchanged", d, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_and_readback();
    t_clear();
    t_mask();
    t_ipi_ack();
    t_hw();
    t_none();
    t_unmapped();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule